// File: doc/BRIEF.md
# Chained Reset-Timer Capture/Compare Unit

This block groups a fixed chain of timer cells into one logical unit. The lowest cell is a reset timer. It advances a shared time base on each qualified count pulse and passes a compare-enable strobe up the chain. The next cell is a compare cell. It watches the time base against a programmed threshold and a select-line condition. On a hit it sends an event back that returns the timer to zero. The cells above it are capture cells. Each one watches one external input line for a chosen edge and latches the time base when that edge arrives.

Software programs the unit through a simple register write port. Each cell has a pass-on bit that can cut the chain. A cell with pass-on cleared blocks every cell above it from receiving the time-base strobe, so those cells stay idle. A typical use measures pulse widths or periods on the input lines against a time base whose period is set by the compare threshold.

Top module: `crtu_top`

## Requirements
- R1: After reset the timer value, every captured value, every capture flag and the compare event output are all zero.
- R2: The timer increments by one on each clock where cntEn is high and the run bit (address 0, bit 0; reset value 1) is set. Otherwise it holds its value.
- R3: When a count occurs while the timer equals the threshold (address 1, reset value all ones) and the select condition holds, the timer goes to 0 in place of incrementing, and cmpEvt is high for exactly that following cycle. The count period is therefore threshold + 1.
- R4: The select condition is address 2, bits [1:0]. 00 never matches (reset value), 01 needs selLine high, 10 needs selLine low, and 11 matches either level.
- R5: Capture cell k is controlled at address 3+k. Bits [1:0] set the edge mode: 00 off, 01 rising, 10 falling, 11 both. Bits [3:2] select the input line index. An edge that the mode does not select leaves the stored value unchanged.
- R6: A capture latches the current timer value. The stored value and the flag change on the third rising clock edge after the input line changes, and not on the second.
- R7: Each capture cell has a sticky flag. Writing address 5 clears flag k where data bit k is 1. A new capture overwrites the stored value even while the flag is still set.
- R8: Each cell has a pass-on bit: address 0 bit 1 for the timer, address 2 bit 2 for the compare cell, and address 3+k bit 4 for capture cell k. All reset to 1. A capture cell takes events only if every cell below it has pass-on set. With the timer's pass-on cleared, the compare cell never resets the timer.
- R9: Writes to addresses 6 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cntEn | input | 1 | Count pulse for the time base, one per clock when high |
| selLine | input | 1 | Select line checked by the compare cell |
| inPins | input | 4 | External input lines, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 16 | Register write data |
| timerVal | output | 16 | Shared time base value |
| capVal | output | 32 | Captured values, cell k at bits [16k+15:16k] |
| capFlag | output | 2 | Sticky capture flags, one per capture cell |
| cmpEvt | output | 1 | One-cycle compare event that reset the timer |

## Verification
The properties assume that cntEn, selLine and the write port are synchronous to clk and change only away from its rising edge. The input lines may be asynchronous, because they pass through the synchronizer. The stimulus drives every input on the falling edge. It holds each input line level for at least four clocks, so every edge is seen once by the synchronizer and the previous-value compare. It also avoids register writes in the same cycle as a compare hit, so the threshold used by a hit is the one the properties read back.

// File: rtl/crtu_pkg.sv
package crtu_pkg;
  // Strobes sent from control to the time-base register.
  typedef struct packed {
    logic inc;
    logic clear;
  } tmrStrobe_t;

  localparam logic [1:0] COND_NEVER = 2'b00;
  localparam logic [1:0] COND_HIGH  = 2'b01;
  localparam logic [1:0] COND_LOW   = 2'b10;
  localparam logic [1:0] COND_ANY   = 2'b11;
endpackage

// File: rtl/crtu_ctrl.sv
module crtu_ctrl
  import crtu_pkg::*;
#(
  parameter int TMR_W   = 16,
  parameter int NUM_CAP = 2,
  parameter int NUM_IN  = 4,
  parameter int ADDR_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cntEn,
  input  logic                 selLine,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [TMR_W-1:0]     wrData,
  input  logic [TMR_W-1:0]     timerVal,
  input  logic [NUM_IN-1:0]    riseVec,
  input  logic [NUM_IN-1:0]    fallVec,
  output tmrStrobe_t           tmrStb,
  output logic [NUM_CAP-1:0]   capLoad,
  output logic [NUM_CAP-1:0]   flagClr,
  output logic [TMR_W-1:0]     threshold,
  output logic [1:0]           cmpCond,
  output logic                 cmpEvt
);
  localparam int SEL_W        = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  localparam int CAP_PASS_BIT = 2 + SEL_W;
  localparam int CAP_BASE     = 3;
  localparam int FLAG_ADDR    = CAP_BASE + NUM_CAP;

  logic                runBit;
  logic                tmrPass;
  logic                cmpPass;
  logic [1:0]          capEdge [NUM_CAP];
  logic [SEL_W-1:0]    capSel  [NUM_CAP];
  logic [NUM_CAP-1:0]  capPass;
  logic                condOk;
  logic                cmpHit;
  logic [NUM_CAP:0]    reach;

  // Register file
  always_ff @(posedge clk) begin
    if (rst) begin
      runBit    <= 1'b1;
      tmrPass   <= 1'b1;
      threshold <= '1;
      cmpCond   <= COND_NEVER;
      cmpPass   <= 1'b1;
      capPass   <= '1;
      for (int k = 0; k < NUM_CAP; k++) begin
        capEdge[k] <= 2'b00;
        capSel[k]  <= '0;
      end
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_W'(0): begin
          runBit  <= wrData[0];
          tmrPass <= wrData[1];
        end
        ADDR_W'(1): threshold <= wrData;
        ADDR_W'(2): begin
          cmpCond <= wrData[1:0];
          cmpPass <= wrData[2];
        end
        default: ;
      endcase
      for (int k = 0; k < NUM_CAP; k++) begin
        if (wrAddr == ADDR_W'(CAP_BASE + k)) begin
          capEdge[k] <= wrData[1:0];
          capSel[k]  <= wrData[2 +: SEL_W];
          capPass[k] <= wrData[CAP_PASS_BIT];
        end
      end
    end
  end

  // Select-line qualification of the compare cell
  always_comb begin
    case (cmpCond)
      COND_HIGH: condOk = selLine;
      COND_LOW:  condOk = ~selLine;
      COND_ANY:  condOk = 1'b1;
      default:   condOk = 1'b0;
    endcase
  end

  assign tmrStb.inc   = cntEn & runBit;
  assign cmpHit       = tmrStb.inc & tmrPass & (timerVal == threshold) & condOk;
  assign tmrStb.clear = cmpHit;

  always_ff @(posedge clk) begin
    if (rst) cmpEvt <= 1'b0;
    else     cmpEvt <= cmpHit;
  end

  // Chain reach: a cell is fed only while every lower cell passes on
  assign reach[0] = tmrPass & cmpPass;

  for (genvar k = 0; k < NUM_CAP; k++) begin : g_cap
    assign reach[k+1] = reach[k] & capPass[k];
    assign capLoad[k] = reach[k] &
                        ((capEdge[k][0] & riseVec[capSel[k]]) |
                         (capEdge[k][1] & fallVec[capSel[k]]));
    assign flagClr[k] = wrEn & (wrAddr == ADDR_W'(FLAG_ADDR)) & wrData[k];
  end
endmodule

// File: rtl/crtu_dp.sv
module crtu_dp
  import crtu_pkg::*;
#(
  parameter int TMR_W   = 16,
  parameter int NUM_CAP = 2,
  parameter int NUM_IN  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_IN-1:0]          inPins,
  input  tmrStrobe_t                 tmrStb,
  input  logic [NUM_CAP-1:0]         capLoad,
  input  logic [NUM_CAP-1:0]         flagClr,
  output logic [TMR_W-1:0]           timerVal,
  output logic [NUM_IN-1:0]          riseVec,
  output logic [NUM_IN-1:0]          fallVec,
  output logic [NUM_CAP*TMR_W-1:0]   capVal,
  output logic [NUM_CAP-1:0]         capFlag
);
  logic [NUM_IN-1:0] syncA;
  logic [NUM_IN-1:0] syncB;
  logic [NUM_IN-1:0] prevIn;

  // Shared time base
  always_ff @(posedge clk) begin
    if (rst)               timerVal <= '0;
    else if (tmrStb.clear) timerVal <= '0;
    else if (tmrStb.inc)   timerVal <= timerVal + 1'b1;
  end

  // Two-flop synchronizer and previous-value compare
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA  <= '0;
      syncB  <= '0;
      prevIn <= '0;
    end else begin
      syncA  <= inPins;
      syncB  <= syncA;
      prevIn <= syncB;
    end
  end

  assign riseVec = syncB & ~prevIn;
  assign fallVec = ~syncB & prevIn;

  // Capture registers and sticky flags
  for (genvar k = 0; k < NUM_CAP; k++) begin : g_store
    always_ff @(posedge clk) begin
      if (rst) begin
        capVal[k*TMR_W +: TMR_W] <= '0;
        capFlag[k]               <= 1'b0;
      end else if (capLoad[k]) begin
        capVal[k*TMR_W +: TMR_W] <= timerVal;
        capFlag[k]               <= 1'b1;
      end else if (flagClr[k]) begin
        capFlag[k]               <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/crtu_top.sv
module crtu_top
  import crtu_pkg::*;
#(
  parameter int TMR_W   = 16,
  parameter int NUM_CAP = 2,
  parameter int NUM_IN  = 4,
  parameter int ADDR_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cntEn,
  input  logic                      selLine,
  input  logic [NUM_IN-1:0]         inPins,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [TMR_W-1:0]          wrData,
  output logic [TMR_W-1:0]          timerVal,
  output logic [NUM_CAP*TMR_W-1:0]  capVal,
  output logic [NUM_CAP-1:0]        capFlag,
  output logic                      cmpEvt
);
  tmrStrobe_t         tmrStb;
  logic [NUM_CAP-1:0] capLoad;
  logic [NUM_CAP-1:0] flagClr;
  logic [NUM_IN-1:0]  riseVec;
  logic [NUM_IN-1:0]  fallVec;
  logic [TMR_W-1:0]   threshold;
  logic [1:0]         cmpCond;

  crtu_ctrl #(
    .TMR_W(TMR_W), .NUM_CAP(NUM_CAP), .NUM_IN(NUM_IN), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cntEn(cntEn), .selLine(selLine),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timerVal(timerVal), .riseVec(riseVec), .fallVec(fallVec),
    .tmrStb(tmrStb), .capLoad(capLoad), .flagClr(flagClr),
    .threshold(threshold), .cmpCond(cmpCond), .cmpEvt(cmpEvt)
  );

  crtu_dp #(
    .TMR_W(TMR_W), .NUM_CAP(NUM_CAP), .NUM_IN(NUM_IN)
  ) u_dp (
    .clk(clk), .rst(rst), .inPins(inPins), .tmrStb(tmrStb),
    .capLoad(capLoad), .flagClr(flagClr), .timerVal(timerVal),
    .riseVec(riseVec), .fallVec(fallVec), .capVal(capVal), .capFlag(capFlag)
  );
endmodule

// File: rtl/crtu_chk.sv
module crtu_chk #(
  parameter int TMR_W   = 16,
  parameter int NUM_CAP = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      cntEn,
  input logic [TMR_W-1:0]          timerVal,
  input logic                      cmpEvt,
  input logic [TMR_W-1:0]          threshold,
  input logic [1:0]                cmpCond,
  input logic [NUM_CAP-1:0]        capLoad,
  input logic [NUM_CAP*TMR_W-1:0]  capVal,
  input logic [NUM_CAP-1:0]        capFlag
);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cntEn |=> $stable(timerVal));

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    cmpEvt |-> timerVal == '0);

  p_hit_r3: assert property (@(posedge clk) disable iff (rst)
    cmpEvt |-> $past(timerVal) == $past(threshold));

  p_never_r4: assert property (@(posedge clk) disable iff (rst)
    (cmpCond == 2'b00) |=> !cmpEvt);

  for (genvar k = 0; k < NUM_CAP; k++) begin : g_chk
    p_latch_r6: assert property (@(posedge clk) disable iff (rst)
      capLoad[k] |=> capVal[k*TMR_W +: TMR_W] == $past(timerVal));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      capLoad[k] |=> capFlag[k]);
  end
endmodule

bind crtu_top crtu_chk #(.TMR_W(TMR_W), .NUM_CAP(NUM_CAP)) u_chk (
  .clk(clk), .rst(rst), .cntEn(cntEn), .timerVal(timerVal), .cmpEvt(cmpEvt),
  .threshold(threshold), .cmpCond(cmpCond), .capLoad(capLoad),
  .capVal(capVal), .capFlag(capFlag)
);

// File: tb/crtu_top_test.sv
module crtu_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cntEn = 1'b0;
  logic        selLine = 1'b0;
  logic [3:0]  inPins = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] timerVal;
  logic [31:0] capVal;
  logic [1:0]  capFlag;
  logic        cmpEvt;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  crtu_top uut (
    .clk(clk), .rst(rst), .cntEn(cntEn), .selLine(selLine), .inPins(inPins),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .timerVal(timerVal),
    .capVal(capVal), .capFlag(capFlag), .cmpEvt(cmpEvt)
  );

  typedef struct packed {
    logic [15:0] thr;
    logic [1:0]  cond;
    logic        sel;
    logic [7:0]  n;
    logic [15:0] exp;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{16'd4, 2'b01, 1'b1, 8'd12, 16'd2},
    '{16'd4, 2'b01, 1'b0, 8'd12, 16'd12},
    '{16'd3, 2'b10, 1'b0, 8'd10, 16'd2},
    '{16'd3, 2'b10, 1'b1, 8'd10, 16'd10},
    '{16'd6, 2'b11, 1'b0, 8'd20, 16'd6},
    '{16'd6, 2'b00, 1'b1, 8'd20, 16'd20},
    '{16'd0, 2'b11, 1'b1, 8'd5,  16'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    inPins = '0;
    selLine = 1'b0;
    cntEn = 1'b0;
    wrEn = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wrEn = 1'b1;
    wrAddr = a;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulse(input int n);
    cntEn = 1'b1;
    repeat (n) @(negedge clk);
    cntEn = 1'b0;
  endtask

  task automatic waitCy(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finishRun();
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    check("R1 timer", timerVal, 0);
    check("R1 capVal", capVal, 0);
    check("R1 capFlag", capFlag, 0);
    check("R1 cmpEvt", cmpEvt, 0);

    // R3 / R4 table of threshold, select condition and select level
    for (int i = 0; i < NVEC; i++) begin
      doReset();
      wr(4'd1, VECS[i].thr);
      wr(4'd2, {13'd0, 1'b1, VECS[i].cond});
      selLine = VECS[i].sel;
      pulse(int'(VECS[i].n));
      check("R3 R4 period", timerVal, VECS[i].exp);
    end

    // R3 event pulse timing
    doReset();
    wr(4'd1, 16'd2);
    wr(4'd2, 16'h0007);
    pulse(2);
    check("R3 before hit", timerVal, 2);
    pulse(1);
    check("R3 cmpEvt high", cmpEvt, 1);
    check("R3 timer wrapped", timerVal, 0);
    waitCy(1);
    check("R3 cmpEvt single", cmpEvt, 0);

    // R2 run bit
    doReset();
    wr(4'd0, 16'h0002);
    pulse(4);
    check("R2 stopped", timerVal, 0);
    wr(4'd0, 16'h0003);
    pulse(3);
    check("R2 running", timerVal, 3);

    // R5 R6 R7 capture behaviour
    doReset();
    wr(4'd3, 16'h0015);
    wr(4'd4, 16'h001A);
    pulse(7);
    inPins[1] = 1'b1;
    waitCy(2);
    check("R6 not yet", capFlag[0], 0);
    waitCy(1);
    check("R6 value", capVal[15:0], 7);
    check("R6 flag", capFlag[0], 1);
    pulse(3);
    inPins[1] = 1'b0;
    waitCy(4);
    check("R5 fall ignored", capVal[15:0], 7);
    wr(4'd5, 16'h0001);
    check("R7 clear", capFlag[0], 0);
    inPins[2] = 1'b1;
    waitCy(4);
    check("R5 rise ignored", capFlag[1], 0);
    pulse(2);
    inPins[2] = 1'b0;
    waitCy(4);
    check("R5 fall value", capVal[31:16], 12);
    check("R5 fall flag", capFlag[1], 1);
    pulse(3);
    inPins[1] = 1'b1;
    waitCy(4);
    check("R7 recapture", capVal[15:0], 15);
    pulse(1);
    wr(4'd3, 16'h0017);
    inPins[1] = 1'b0;
    waitCy(4);
    check("R7 overwrite", capVal[15:0], 16);
    check("R7 still set", capFlag[0], 1);

    // R8 chain pass-on
    doReset();
    wr(4'd3, 16'h0001);
    wr(4'd4, 16'h0011);
    pulse(5);
    inPins[0] = 1'b1;
    waitCy(4);
    check("R8 cell0 fed", capVal[15:0], 5);
    check("R8 cell1 blocked", capFlag[1], 0);
    wr(4'd5, 16'h0003);
    wr(4'd2, 16'h0000);
    wr(4'd3, 16'h0013);
    inPins[0] = 1'b0;
    waitCy(4);
    check("R8 compare cut", capFlag[0], 0);
    wr(4'd0, 16'h0001);
    wr(4'd1, 16'd2);
    wr(4'd2, 16'h0007);
    pulse(6);
    check("R8 no reset", timerVal, 11);
    inPins[0] = 1'b1;
    waitCy(4);
    check("R8 timer cut", capFlag[0], 0);

    // R9 unused addresses
    doReset();
    wr(4'd3, 16'h0011);
    pulse(6);
    inPins[0] = 1'b1;
    waitCy(4);
    check("R9 setup", capVal[15:0], 6);
    wr(4'd9, 16'hFFFF);
    wr(4'd15, 16'hFFFF);
    check("R9 flag kept", capFlag[0], 1);
    pulse(2);
    check("R9 timer", timerVal, 8);
    check("R9 no event", cmpEvt, 0);

    finishRun();
  end
endmodule